// File: doc/BRIEF.md
# Mesh Router Straight-Hop Bypass Decision Unit

This unit sits inside one router of a two-dimensional mesh. The router has five ports: Local, North, South, East and West. For every flit that arrives in a cycle, the unit decides which of three ways the flit takes.

- **Allocation bypass.** The flit skips allocation and enters the crossbar at once.
- **Switch-traversal bypass.** The flit skips the crossbar as well. It takes a dedicated wire from its input to the opposite output, and that path is clocked on the falling edge.
- **Normal path.** The flit is written into its input VC buffer and goes through the usual allocation pipeline.

The decision uses the input's valid bit, its 3-bit route code, its VC id and whether its designated-VC queue is empty. It also uses two per-output vectors. One marks outputs already claimed this cycle by a flit from the allocated pipeline. The other marks outputs whose downstream designated VC still has a credit.

Bypass is limited to three kinds of move: straight hops (East/West or North/South, to the opposite port), injection from the Local input, and ejection to the Local output. A flit that turns between dimensions always takes the normal path. The grants are combinational in the arrival cycle. Crossbar traffic from allocation-bypassed flits is registered on the next rising edge. Traffic on the dedicated straight paths is registered on the falling edge of the arrival cycle, half a cycle earlier.

Top module: `hopskip_unit`

## Requirements
- R1: A valid flit with a legal route is granted allocation bypass when it is a straight hop to the opposite port, or enters from Local, or exits to Local, and it does not meet the conditions of R4. This holds only while R6 and R7 allow the grant.
- R2: A flit whose route turns between dimensions, or whose route names its own input port, is never granted either bypass and is sent to the buffer (to_buf_o).
- R3: For each allocation-bypassed flit, on the next rising edge the crossbar output register at its target port shows valid=1, the source port code and the flit data. Outputs with no such flit show valid=0, source 0 and data 0.
- R4: Switch-traversal bypass (instead of allocation bypass) is granted only to a straight-hop flit from a non-local input whose VC id equals the designated VC (default 0) and whose designated-VC queue is empty.
- R5: A switch-traversal-bypassed flit appears on the dedicated output opposite its input at the falling edge of its arrival cycle, with valid=1 and its data. The Local dedicated output stays at valid=0 and data 0.
- R6: No bypass of either kind is granted toward an output whose claim bit is set, or whose downstream credit bit is clear. Such a flit goes to the buffer.
- R7: At most one bypass is granted per output per cycle. A straight-hop candidate beats a Local injection to the same output. Among ejections to Local, the lowest port code wins. Losers go to the buffer.
- R8: Port codes are 0 Local, 1 North, 2 South, 3 East, 4 West. Route codes 5 to 7 are illegal and always send a valid flit to the buffer.
- R9: After reset, every registered output reads zero.
- R10: Each valid input gets exactly one of allocation bypass, switch-traversal bypass or buffer. An input with valid=0 gets none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge for the crossbar register, falling edge for the straight paths |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld_i | input | 5 | Flit valid, one bit per input port |
| in_route_i | input | 15 | 3-bit target port code per input |
| in_vc_i | input | 5*VC_W | VC id per input |
| in_vcq_empty_i | input | 5 | Designated-VC queue of the input is empty |
| in_flit_i | input | 5*DATA_W | Flit data per input |
| out_claim_i | input | 5 | Output taken this cycle by the allocated pipeline |
| dn_credit_i | input | 5 | Downstream designated VC of the output has a credit |
| alloc_byp_o | output | 5 | Allocation-bypass grant per input |
| st_byp_o | output | 5 | Switch-traversal-bypass grant per input |
| to_buf_o | output | 5 | Input flit goes to its VC buffer |
| xb_vld_o | output | 5 | Crossbar output register valid per output |
| xb_src_o | output | 15 | Source port code per crossbar output |
| xb_flit_o | output | 5*DATA_W | Crossbar output data |
| stp_vld_o | output | 5 | Dedicated straight-path output valid per output |
| stp_flit_o | output | 5*DATA_W | Dedicated straight-path output data |

## Verification
Several properties are checked by assertions on every rising edge:

- No turn or U-turn receives a grant.
- No grant goes to a claimed or credit-less output.
- Switch-traversal grants go only to designated-VC head flits from non-local inputs.
- Each valid flit has exactly one fate.
- An allocation bypass is followed by a valid crossbar register at its target.
- No output receives two grants.

Some behaviours can only be shown by the bench scenarios, run against a behavioural model. These are the priority order between competing candidates, the data and source codes carried through both registered paths, the half-cycle timing of the straight path, the silence of the Local straight output, and the handling of illegal route codes.

// File: rtl/hopskip_pkg.sv
package hopskip_pkg;
    localparam int NP = 5;
    localparam int PW = 3;

    typedef enum logic [PW-1:0] {
        P_LOC = 3'd0,
        P_NTH = 3'd1,
        P_STH = 3'd2,
        P_EST = 3'd3,
        P_WST = 3'd4
    } port_e;

    // Opposite port of a mesh direction; Local has none (returns 7).
    function automatic logic [PW-1:0] opp_of(input logic [PW-1:0] p);
        case (p)
            P_NTH:   opp_of = P_STH;
            P_STH:   opp_of = P_NTH;
            P_EST:   opp_of = P_WST;
            P_WST:   opp_of = P_EST;
            default: opp_of = 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/hopskip_elig.sv
module hopskip_elig
    import hopskip_pkg::*;
#(
    parameter int IN_PORT  = 0,
    parameter int VC_W     = 2,
    parameter int DESIG_VC = 0
) (
    input  logic            vld_i,
    input  logic [PW-1:0]   route_i,
    input  logic [VC_W-1:0] vc_i,
    input  logic            vcq_empty_i,
    input  logic [NP-1:0]   claim_i,
    input  logic [NP-1:0]   credit_i,
    output logic [NP-1:0]   req_o,
    output logic            st_kind_o
);
    localparam logic [PW-1:0]   SELF = PW'(IN_PORT);
    localparam logic [VC_W-1:0] DV   = VC_W'(DESIG_VC);

    logic [7:0] claim_x, credit_x;
    logic       legal, straight, edge_hop, free;

    always_comb begin
        claim_x  = {3'b000, claim_i};
        credit_x = {3'b000, credit_i};
        legal    = (route_i <= 3'd4) && (route_i != SELF);
        straight = (route_i == opp_of(SELF));
        edge_hop = (SELF == P_LOC) || (route_i == P_LOC);
        free     = !claim_x[route_i] && credit_x[route_i];
        req_o    = '0;
        if (vld_i && legal && (straight || edge_hop) && free)
            req_o[route_i] = 1'b1;
        st_kind_o = straight && (vc_i == DV) && vcq_empty_i;
    end
endmodule

// File: rtl/hopskip_arb.sv
module hopskip_arb
    import hopskip_pkg::*;
#(
    parameter int OUT_PORT = 0
) (
    input  logic [NP-1:0] req_i,
    output logic [NP-1:0] gnt_o
);
    localparam logic [PW-1:0] SELF = PW'(OUT_PORT);

    // Straight candidate (the opposite input) first, then ascending port code.
    always_comb begin
        gnt_o = '0;
        if (SELF != P_LOC && req_i[3'(opp_of(SELF))]) begin
            gnt_o[3'(opp_of(SELF))] = 1'b1;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (req_i[i] && gnt_o == '0) gnt_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hopskip_stpath.sv
module hopskip_stpath
    import hopskip_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        st_gnt_i,
    input  logic [NP*DATA_W-1:0] flit_i,
    output logic [NP-1:0]        vld_o,
    output logic [NP*DATA_W-1:0] flit_o
);
    typedef struct packed {
        logic [NP-1:0]        vld;
        logic [NP*DATA_W-1:0] flit;
    } stp_s;

    stp_s st_d, st_q;

    // Dedicated wires: input opp(o) to output o, none for Local.
    always_comb begin
        st_d = '0;
        for (int o = 1; o < NP; o++) begin
            if (st_gnt_i[int'(opp_of(3'(o)))]) begin
                st_d.vld[o] = 1'b1;
                st_d.flit[o*DATA_W +: DATA_W] =
                    flit_i[int'(opp_of(3'(o)))*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(negedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign flit_o = st_q.flit;
endmodule

// File: rtl/hopskip_unit.sv
module hopskip_unit
    import hopskip_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int VC_W     = 2,
    parameter int DESIG_VC = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_vld_i,
    input  logic [NP*PW-1:0]     in_route_i,
    input  logic [NP*VC_W-1:0]   in_vc_i,
    input  logic [NP-1:0]        in_vcq_empty_i,
    input  logic [NP*DATA_W-1:0] in_flit_i,
    input  logic [NP-1:0]        out_claim_i,
    input  logic [NP-1:0]        dn_credit_i,
    output logic [NP-1:0]        alloc_byp_o,
    output logic [NP-1:0]        st_byp_o,
    output logic [NP-1:0]        to_buf_o,
    output logic [NP-1:0]        xb_vld_o,
    output logic [NP*PW-1:0]     xb_src_o,
    output logic [NP*DATA_W-1:0] xb_flit_o,
    output logic [NP-1:0]        stp_vld_o,
    output logic [NP*DATA_W-1:0] stp_flit_o
);
    localparam logic [VC_W-1:0] DV = VC_W'(DESIG_VC);

    typedef struct packed {
        logic [NP-1:0]        vld;
        logic [NP*PW-1:0]     src;
        logic [NP*DATA_W-1:0] flit;
    } xb_s;

    logic [NP-1:0] req_m [NP];   // [input][output]
    logic [NP-1:0] col_m [NP];   // [output][input]
    logic [NP-1:0] gnt_m [NP];   // [output][input]
    logic [NP-1:0] st_kind;
    logic [NP-1:0] granted;
    logic [PW-1:0] rt_w  [NP];
    xb_s           xb_d, xb_q;

    for (genvar i = 0; i < NP; i++) begin : g_in
        assign rt_w[i] = in_route_i[i*PW +: PW];
        hopskip_elig #(
            .IN_PORT (i),
            .VC_W    (VC_W),
            .DESIG_VC(DESIG_VC)
        ) elig_i (
            .vld_i      (in_vld_i[i]),
            .route_i    (rt_w[i]),
            .vc_i       (in_vc_i[i*VC_W +: VC_W]),
            .vcq_empty_i(in_vcq_empty_i[i]),
            .claim_i    (out_claim_i),
            .credit_i   (dn_credit_i),
            .req_o      (req_m[i]),
            .st_kind_o  (st_kind[i])
        );
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        for (genvar i = 0; i < NP; i++) begin : g_tr
            assign col_m[o][i] = req_m[i][o];
        end
        hopskip_arb #(.OUT_PORT(o)) arb_i (
            .req_i(col_m[o]),
            .gnt_o(gnt_m[o])
        );
    end

    always_comb begin
        granted = '0;
        for (int o = 0; o < NP; o++) granted |= gnt_m[o];
        alloc_byp_o = granted & ~st_kind;
        st_byp_o    = granted & st_kind;
        to_buf_o    = in_vld_i & ~granted;
    end

    // Crossbar output register, rising edge.
    always_comb begin
        xb_d = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (gnt_m[o][i] && !st_kind[i]) begin
                    xb_d.vld[o]                   = 1'b1;
                    xb_d.src[o*PW +: PW]          = PW'(i);
                    xb_d.flit[o*DATA_W +: DATA_W] = in_flit_i[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xb_q <= '0;
        else        xb_q <= xb_d;
    end

    assign xb_vld_o  = xb_q.vld;
    assign xb_src_o  = xb_q.src;
    assign xb_flit_o = xb_q.flit;

    hopskip_stpath #(.DATA_W(DATA_W)) stp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_gnt_i(st_byp_o),
        .flit_i  (in_flit_i),
        .vld_o   (stp_vld_o),
        .flit_o  (stp_flit_o)
    );

    logic [7:0] claim8, cred8, xbv8;
    assign claim8 = {3'b000, out_claim_i};
    assign cred8  = {3'b000, dn_credit_i};
    assign xbv8   = {3'b000, xb_vld_o};

    for (genvar i = 0; i < NP; i++) begin : g_ast_in
        AST_NO_TURN: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_byp_o[i] || st_byp_o[i]) |->
            (rt_w[i] == opp_of(PW'(i)) || i == 0 || rt_w[i] == P_LOC)) // R2
            else $error("turn bypassed");
        AST_OUT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_byp_o[i] || st_byp_o[i]) |->
            (!claim8[rt_w[i]] && cred8[rt_w[i]])) // R6
            else $error("bypass to busy output");
        AST_ST_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            st_byp_o[i] |->
            (i != 0 && in_vc_i[i*VC_W +: VC_W] == DV && in_vcq_empty_i[i])) // R4
            else $error("bad switch bypass");
        AST_ONE_FATE: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld_i[i] |-> $onehot({alloc_byp_o[i], st_byp_o[i], to_buf_o[i]})) // R10
            else $error("fate not unique");
        AST_XB_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_byp_o[i] |=> xbv8[$past(rt_w[i])]) // R3
            else $error("crossbar register missing");
    end

    for (genvar o = 0; o < NP; o++) begin : g_ast_out
        AST_ONE_PER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_m[o])) // R7
            else $error("two grants one output");
    end
endmodule

// File: tb/hopskip_unit_tb_top.sv
`timescale 1ns/100ps
module hopskip_unit_tb_top;
    localparam int NP = 5, PW = 3, DW = 32, VW = 2;
    localparam int OPPT [5] = '{-1, 2, 1, 4, 3};

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]    in_vld, in_emp, claim, cred;
    logic [NP*PW-1:0] in_rt;
    logic [NP*VW-1:0] in_vc;
    logic [NP*DW-1:0] in_flit;
    logic [NP-1:0]    alloc_byp, st_byp, to_buf, xb_vld, stp_vld;
    logic [NP*PW-1:0] xb_src;
    logic [NP*DW-1:0] xb_flit, stp_flit;

    hopskip_unit #(.DATA_W(DW), .VC_W(VW), .DESIG_VC(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .in_route_i(in_rt),
        .in_vc_i(in_vc), .in_vcq_empty_i(in_emp), .in_flit_i(in_flit),
        .out_claim_i(claim), .dn_credit_i(cred), .alloc_byp_o(alloc_byp),
        .st_byp_o(st_byp), .to_buf_o(to_buf), .xb_vld_o(xb_vld),
        .xb_src_o(xb_src), .xb_flit_o(xb_flit), .stp_vld_o(stp_vld),
        .stp_flit_o(stp_flit));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R9", prev_req = "R9";

    int v[5], rt[5], vc[5], emp[5], cl[5], cr[5];
    logic [DW-1:0] fl[5];

    logic [NP-1:0]    e_alloc, e_st, e_buf, e_xv, e_sv;
    logic [NP*PW-1:0] e_xs;
    logic [NP*DW-1:0] e_xf, e_sf;
    logic [NP-1:0]    p_xv;
    logic [NP*PW-1:0] p_xs;
    logic [NP*DW-1:0] p_xf;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        for (int i = 0; i < NP; i++) begin
            v[i] = 0; rt[i] = 0; vc[i] = 1; emp[i] = 1; cl[i] = 0; cr[i] = 1;
            fl[i] = 32'hA000_0000 + i;
        end
    endtask

    // Behavioural reference.
    task automatic model();
        int elig[5], winner;
        e_alloc = 0; e_st = 0; e_buf = 0; e_xv = 0; e_sv = 0;
        e_xs = 0; e_xf = 0; e_sf = 0;
        for (int i = 0; i < NP; i++) begin
            elig[i] = 0;
            if (v[i] != 0 && rt[i] <= 4 && rt[i] != i &&
                (rt[i] == OPPT[i] || i == 0 || rt[i] == 0))
                elig[i] = (cl[rt[i]] == 0 && cr[rt[i]] != 0) ? 1 : 0;
        end
        for (int o = 0; o < NP; o++) begin
            winner = -1;
            if (o != 0 && elig[OPPT[o]] != 0 && rt[OPPT[o]] == o) winner = OPPT[o];
            for (int i = 0; i < NP; i++)
                if (winner < 0 && elig[i] != 0 && rt[i] == o) winner = i;
            if (winner >= 0) begin
                if (winner != 0 && rt[winner] == OPPT[winner] && vc[winner] == 0 &&
                    emp[winner] != 0) begin
                    e_st[winner] = 1;
                    e_sv[o] = 1;
                    e_sf[o*DW +: DW] = fl[winner];
                end else begin
                    e_alloc[winner] = 1;
                    e_xv[o] = 1;
                    e_xs[o*PW +: PW] = 3'(winner);
                    e_xf[o*DW +: DW] = fl[winner];
                end
            end
        end
        for (int i = 0; i < NP; i++)
            if (v[i] != 0 && !e_alloc[i] && !e_st[i]) e_buf[i] = 1;
    endtask

    task automatic drive();
        for (int i = 0; i < NP; i++) begin
            in_vld[i] = v[i][0]; in_emp[i] = emp[i][0];
            claim[i] = cl[i][0]; cred[i] = cr[i][0];
            in_rt[i*PW +: PW] = 3'(rt[i]);
            in_vc[i*VW +: VW] = 2'(vc[i]);
            in_flit[i*DW +: DW] = fl[i];
        end
    endtask

    task automatic step();
        @(posedge clk);
        #0.5;
        chk(xb_vld == p_xv, prev_req, "xb_vld", xb_vld, p_xv);
        chk(xb_src == p_xs, prev_req, "xb_src", xb_src, p_xs);
        chk(xb_flit == p_xf, prev_req, "xb_flit", xb_flit, p_xf);
        #0.5;
        drive();
        model();
        #1;
        chk(alloc_byp == e_alloc, cur_req, "alloc_byp", alloc_byp, e_alloc);
        chk(st_byp == e_st, cur_req, "st_byp", st_byp, e_st);
        chk(to_buf == e_buf, cur_req, "to_buf", to_buf, e_buf);
        @(negedge clk);
        #1;
        chk(stp_vld == e_sv, cur_req, "stp_vld", stp_vld, e_sv);
        chk(stp_flit == e_sf, cur_req, "stp_flit", stp_flit, e_sf);
        p_xv = e_xv; p_xs = e_xs; p_xf = e_xf;
        prev_req = cur_req;
    endtask

    initial begin
        clear_in(); drive();
        p_xv = 0; p_xs = 0; p_xf = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(xb_vld == 0 && xb_flit == 0 && xb_src == 0, "R9", "xb reset", xb_vld, 0);
        chk(stp_vld == 0 && stp_flit == 0, "R9", "stp reset", stp_vld, 0);
        rst_n = 1;

        // R1: straight (West->East, VC 1), injection L->N, ejection S->L
        cur_req = "R1"; clear_in();
        v[4] = 1; rt[4] = 3; v[0] = 1; rt[0] = 1; v[2] = 1; rt[2] = 0;
        step();
        // R3: crossbar register contents
        cur_req = "R3"; clear_in();
        v[1] = 1; rt[1] = 2; fl[1] = 32'h1234_5678; v[3] = 1; rt[3] = 0;
        step();
        // R2: turn and U-turn
        cur_req = "R2"; clear_in();
        v[1] = 1; rt[1] = 3; v[3] = 1; rt[3] = 3; v[4] = 1; rt[4] = 1;
        step();
        // R4: designated VC head vs not head vs other VC
        cur_req = "R4"; clear_in();
        v[2] = 1; rt[2] = 1; vc[2] = 0; emp[2] = 1;
        v[3] = 1; rt[3] = 4; vc[3] = 0; emp[3] = 0;
        v[1] = 1; rt[1] = 2; vc[1] = 2; emp[1] = 1;
        step();
        // R5: all four straight paths at once
        cur_req = "R5"; clear_in();
        for (int i = 1; i < NP; i++) begin
            v[i] = 1; rt[i] = OPPT[i]; vc[i] = 0; fl[i] = 32'h5500_0000 + i;
        end
        step();
        // R6: claimed output and missing credit
        cur_req = "R6"; clear_in();
        v[4] = 1; rt[4] = 3; cl[3] = 1;
        v[1] = 1; rt[1] = 2; cr[2] = 0;
        v[0] = 1; rt[0] = 4; cl[4] = 1;
        step();
        // R7: straight beats injection; lowest code wins ejection
        cur_req = "R7"; clear_in();
        v[4] = 1; rt[4] = 3; v[0] = 1; rt[0] = 3;
        v[1] = 1; rt[1] = 0; v[3] = 1; rt[3] = 0; v[2] = 1; rt[2] = 0;
        step();
        cur_req = "R7"; clear_in();
        v[2] = 1; rt[2] = 1; vc[2] = 0; v[0] = 1; rt[0] = 1;
        step();
        // R8: illegal route codes
        cur_req = "R8"; clear_in();
        v[0] = 1; rt[0] = 5; v[1] = 1; rt[1] = 6; v[4] = 1; rt[4] = 7;
        step();
        // R10: random traffic, including invalid inputs
        cur_req = "R10";
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NP; i++) begin
                v[i]   = ($urandom_range(0, 9) < 7) ? 1 : 0;
                rt[i]  = ($urandom_range(0, 15) == 0) ? int'($urandom_range(5, 7))
                                                      : int'($urandom_range(0, 4));
                vc[i]  = $urandom_range(0, 3);
                emp[i] = $urandom_range(0, 1);
                cl[i]  = ($urandom_range(0, 5) == 0) ? 1 : 0;
                cr[i]  = ($urandom_range(0, 5) != 0) ? 1 : 0;
                fl[i]  = $urandom;
            end
            step();
        end
        clear_in();
        step();
        step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule